// File: doc/BRIEF.md
# PTP Event Timestamp Capture Unit

This block watches a byte-wide frame stream beside an Ethernet MAC, on either the receive or the transmit side. It copies a free-running time-of-day value on the first byte of every frame, before any parsing. It then reads the 34-byte PTP common header and keeps the copied time only when the message is one of the four timing-critical event kinds.

The header is found in one of two ways. In raw Ethernet mode it follows a 14-byte MAC header whose EtherType must be 0x88F7. In offset mode it starts at a byte offset set by configuration, for example behind IP/UDP headers. A matching event message pushes one record into a small first-in first-out queue. The record holds the message type, domain, sequence number and timestamp. All other frames leave no trace.

The input stream has no ready signal, because a MAC cannot be stalled, so every byte with `in_valid` high is consumed. The record output is valid/ready. A record stays on the output, unchanged, until it is taken. When the queue is full, a new record is dropped and a saturating overflow counter counts it. Fullness is judged on the queue occupancy before any pop in the same cycle.

Top module: `ptp_event_stamper`

## Requirements
- R1: The record timestamp equals the `tod` value present on the clock edge at which the frame's first byte (`in_valid` and `in_sof` high) is accepted.
- R2: The low nibble of header byte 0 is the message type. Types 0, 1, 2 and 3 produce one record. The record carries that type, the domain from header byte 4, and the sequence number from header bytes 30 and 31, most significant byte first.
- R3: Message types 8 through 0xD produce no record.
- R4: Reserved message types 4 through 7, 0xE and 0xF produce no record.
- R5: The high nibble of header byte 0 selects a bit of `cfg_ts_mask`. When that bit is 0, no record is produced.
- R6: With `cfg_raw` = 1, frame bytes 12 and 13 must be 0x88 and 0xF7, and the header starts at frame byte 14. Any other EtherType produces no record.
- R7: With `cfg_raw` = 0, the header starts at frame byte `cfg_hdr_offset`, and no EtherType is checked.
- R8: A frame whose last byte (`in_eof`) comes before header byte 33 produces no record. A frame that ends exactly on header byte 33 does produce a record.
- R9: While `rec_valid` is high and `rec_ready` is low, the record stays on the output unchanged. Records leave the queue in the order their frames arrived.
- R10: A record that arrives while the queue is full is dropped, and `ovf_count` goes up by one, saturating at its maximum.
- R11: After reset, `rec_valid` is 0 and `ovf_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tod | input | TS_W | Free-running time-of-day value |
| in_valid | input | 1 | Byte strobe of the frame stream |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_data | input | 8 | Frame byte |
| cfg_raw | input | 1 | 1: raw Ethernet mode, 0: offset mode |
| cfg_hdr_offset | input | OFF_W | Header start byte in offset mode |
| cfg_ts_mask | input | 16 | Accepted transport nibble values, one bit each |
| rec_valid | output | 1 | A record is available |
| rec_ready | input | 1 | Consumer takes the record |
| rec_ts | output | TS_W | Captured timestamp |
| rec_type | output | 4 | Event message type |
| rec_domain | output | 8 | Domain number |
| rec_seq | output | 16 | Sequence number |
| ovf_count | output | OVF_W | Records lost to a full queue |

## Verification
The bench moves the time-of-day value on every cycle. A design that sampled it after parsing, instead of at the first byte, would return a later value. Each of the sixteen message type codes is sent once. A decode that trusted only one type bit would let general or reserved types through. The bench also covers a frame cut one byte short of the header end, next to a frame that ends exactly on the last header byte, which catches an off-by-one in the completion test. Other cases are a wrong EtherType, a disabled transport nibble, a zero header offset, and holding the queue stalled past capacity. A queue that overwrote its oldest entry, or a counter that missed a drop, would show up in the drained sequence numbers.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;
  localparam int unsigned HDR_BYTES   = 34;
  localparam int unsigned RAW_HDR_POS = 14;
  localparam int unsigned ETYPE_POS   = 12;
  localparam logic [7:0]  ETYPE_HI    = 8'h88;
  localparam logic [7:0]  ETYPE_LO    = 8'hF7;
  localparam int unsigned DOM_POS     = 4;
  localparam int unsigned SEQ_POS     = 30;

  typedef enum logic [1:0] {CLS_EVENT, CLS_GENERAL, CLS_RESERVED} msg_class_e;

  function automatic msg_class_e classify(input logic [3:0] mtype);
    if (mtype[3:2] == 2'b00) return CLS_EVENT;
    else if (mtype >= 4'h8 && mtype <= 4'hD) return CLS_GENERAL;
    else return CLS_RESERVED;
  endfunction
endpackage

// File: rtl/ptp_hdr_parser.sv
module ptp_hdr_parser
  import ptp_stamp_pkg::*;
#(
  parameter int unsigned TS_W  = 48,
  parameter int unsigned OFF_W = 8,
  parameter int unsigned CNT_W = OFF_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   tod,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_data,
  input  logic              cfg_raw,
  input  logic [OFF_W-1:0]  cfg_hdr_offset,
  input  logic [15:0]       cfg_ts_mask,
  output logic              push,
  output logic [TS_W-1:0]   push_ts,
  output logic [3:0]        push_type,
  output logic [7:0]        push_dom,
  output logic [15:0]       push_seq
);
  logic [CNT_W-1:0] cnt, idx, hstart, hend;
  logic             active, eth_ok, live;
  logic [3:0]       tspec;

  always_comb begin
    idx    = in_sof ? '0 : cnt;
    hstart = cfg_raw ? CNT_W'(RAW_HDR_POS) : CNT_W'(cfg_hdr_offset);
    hend   = hstart + CNT_W'(HDR_BYTES - 1);
    live   = in_sof | active;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      active    <= 1'b0;
      eth_ok    <= 1'b0;
      tspec     <= '0;
      push      <= 1'b0;
      push_ts   <= '0;
      push_type <= '0;
      push_dom  <= '0;
      push_seq  <= '0;
    end else begin
      push <= 1'b0;
      if (in_valid) begin
        if (idx != '1) cnt <= idx + 1'b1;
        if (in_sof) begin
          push_ts <= tod;   // latched at the first byte, before any parsing
          active  <= 1'b1;
          eth_ok  <= 1'b1;
        end
        if (live) begin
          if (cfg_raw && idx == CNT_W'(ETYPE_POS) && in_data != ETYPE_HI) eth_ok <= 1'b0;
          if (cfg_raw && idx == CNT_W'(ETYPE_POS + 1) && in_data != ETYPE_LO) eth_ok <= 1'b0;
          if (idx == hstart) begin
            tspec     <= in_data[7:4];
            push_type <= in_data[3:0];
          end
          if (idx == hstart + CNT_W'(DOM_POS)) push_dom <= in_data;
          if (idx == hstart + CNT_W'(SEQ_POS)) push_seq[15:8] <= in_data;
          if (idx == hstart + CNT_W'(SEQ_POS + 1)) push_seq[7:0] <= in_data;
          if (idx == hend) begin
            active <= 1'b0;
            push   <= eth_ok && (classify(push_type) == CLS_EVENT) && cfg_ts_mask[tspec];
          end
        end
        if (in_eof) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ptp_ts_queue.sv
module ptp_ts_queue #(
  parameter int unsigned W     = 76,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned OVF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  output logic             full,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data,
  output logic [OVF_W-1:0] ovf_count
);
  localparam int unsigned AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign full      = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign out_valid = (wp != rp);
  assign out_data  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp        <= '0;
      rp        <= '0;
      ovf_count <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (push && full && ovf_count != '1) ovf_count <= ovf_count + 1'b1;
      if (out_valid && out_ready) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/ptp_event_stamper.sv
module ptp_event_stamper #(
  parameter int unsigned TS_W  = 48,
  parameter int unsigned OFF_W = 8,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned OVF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   tod,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_data,
  input  logic              cfg_raw,
  input  logic [OFF_W-1:0]  cfg_hdr_offset,
  input  logic [15:0]       cfg_ts_mask,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [TS_W-1:0]   rec_ts,
  output logic [3:0]        rec_type,
  output logic [7:0]        rec_domain,
  output logic [15:0]       rec_seq,
  output logic [OVF_W-1:0]  ovf_count
);
  localparam int unsigned REC_W = TS_W + 4 + 8 + 16;

  logic              push_v, q_full;
  logic [TS_W-1:0]   p_ts;
  logic [3:0]        p_type;
  logic [7:0]        p_dom;
  logic [15:0]       p_seq;
  logic [REC_W-1:0]  q_out;

  ptp_hdr_parser #(.TS_W(TS_W), .OFF_W(OFF_W)) u_parse (
    .clk(clk), .rst_n(rst_n), .tod(tod),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .cfg_raw(cfg_raw), .cfg_hdr_offset(cfg_hdr_offset), .cfg_ts_mask(cfg_ts_mask),
    .push(push_v), .push_ts(p_ts), .push_type(p_type), .push_dom(p_dom), .push_seq(p_seq)
  );

  ptp_ts_queue #(.W(REC_W), .DEPTH(DEPTH), .OVF_W(OVF_W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(push_v), .push_data({p_ts, p_type, p_dom, p_seq}), .full(q_full),
    .out_valid(rec_valid), .out_ready(rec_ready), .out_data(q_out),
    .ovf_count(ovf_count)
  );

  assign {rec_ts, rec_type, rec_domain, rec_seq} = q_out;
endmodule

// File: rtl/ptp_stamp_checker.sv
module ptp_stamp_checker #(
  parameter int unsigned TS_W  = 48,
  parameter int unsigned OVF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rec_valid,
  input logic             rec_ready,
  input logic [TS_W-1:0]  rec_ts,
  input logic [3:0]       rec_type,
  input logic [7:0]       rec_domain,
  input logic [15:0]      rec_seq,
  input logic [OVF_W-1:0] ovf_count,
  input logic             push,
  input logic             q_full
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_ts) && $stable(rec_type)
                                && $stable(rec_domain) && $stable(rec_seq));

  assert_push_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> rec_valid);

  // R2, R3, R4: only event kinds ever reach the output
  assert_event_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_type[3:2] == 2'b00);

  assert_ovf_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_count != $past(ovf_count) |-> $past(push && q_full)
                                      && ovf_count == $past(ovf_count) + 1'b1);
endmodule

bind ptp_event_stamper ptp_stamp_checker #(.TS_W(TS_W), .OVF_W(OVF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
  .rec_ts(rec_ts), .rec_type(rec_type), .rec_domain(rec_domain), .rec_seq(rec_seq),
  .ovf_count(ovf_count), .push(push_v), .q_full(q_full)
);

// File: tb/tb_ptp_event_stamper.sv
`timescale 1ns/1ps
module tb_ptp_event_stamper;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [47:0] tod;
  logic        in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0]  in_data = 0;
  logic        cfg_raw = 1;
  logic [7:0]  cfg_hdr_offset = 0;
  logic [15:0] cfg_ts_mask = 16'h0003;
  logic        rec_valid, rec_ready = 0;
  logic [47:0] rec_ts;
  logic [3:0]  rec_type;
  logic [7:0]  rec_domain;
  logic [15:0] rec_seq;
  logic [15:0] ovf_count;

  int checks = 0, fails = 0;
  logic [7:0]  frm [0:127];
  logic [47:0] exp_ts;
  logic [47:0] ts_log [0:7];

  always #2.5 clk = ~clk;

  always @(negedge clk) tod <= rst_n ? tod + 48'd7 : 48'h0000_1234_5000;

  ptp_event_stamper dut (
    .clk(clk), .rst_n(rst_n), .tod(tod),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .cfg_raw(cfg_raw), .cfg_hdr_offset(cfg_hdr_offset), .cfg_ts_mask(cfg_ts_mask),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_ts(rec_ts), .rec_type(rec_type),
    .rec_domain(rec_domain), .rec_seq(rec_seq), .ovf_count(ovf_count)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // builds a frame; returns header start position
  task automatic build(input bit raw, input int off, input logic [3:0] tsp, input logic [3:0] mt,
                       input logic [7:0] dom, input logic [15:0] seq, output int hs);
    for (int i = 0; i < 128; i++) frm[i] = 8'(i * 3 + 1);
    if (raw) begin
      frm[12] = 8'h88; frm[13] = 8'hF7; hs = 14;
    end else hs = off;
    frm[hs]      = {tsp, mt};
    frm[hs + 4]  = dom;
    frm[hs + 30] = seq[15:8];
    frm[hs + 31] = seq[7:0];
  endtask

  task automatic send(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); #1;
      in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1); in_data = frm[i];
      if (i == 0) exp_ts = tod;
    end
    @(negedge clk); #1;
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic frame(input bit raw, input int off, input logic [3:0] tsp, input logic [3:0] mt,
                       input logic [7:0] dom, input logic [15:0] seq, input int extra);
    int hs;
    build(raw, off, tsp, mt, dom, seq, hs);
    send(hs + 34 + extra);
  endtask

  task automatic expect_rec(input string tag, input logic [47:0] ts, input logic [3:0] mt,
                            input logic [7:0] dom, input logic [15:0] seq);
    chk(rec_valid === 1'b1, {tag, " valid"}, 64'(rec_valid), 1);
    chk(rec_ts === ts, {tag, " ts"}, 64'(rec_ts), 64'(ts));
    chk(rec_type === mt, {tag, " type"}, 64'(rec_type), 64'(mt));
    chk(rec_domain === dom, {tag, " domain"}, 64'(rec_domain), 64'(dom));
    chk(rec_seq === seq, {tag, " seq"}, 64'(rec_seq), 64'(seq));
    rec_ready = 1;
    @(negedge clk); #1;
    rec_ready = 0;
  endtask

  task automatic expect_none(input string tag);
    chk(rec_valid === 1'b0, {tag, " no record"}, 64'(rec_valid), 0);
  endtask

  task automatic t_reset;
    chk(rec_valid === 1'b0, "R11 rec_valid", 64'(rec_valid), 0);
    chk(ovf_count === 16'd0, "R11 ovf_count", 64'(ovf_count), 0);
  endtask

  task automatic t_sync;
    frame(1, 0, 4'h0, 4'h0, 8'h2A, 16'hBEEF, 4); idle(3);
    expect_rec("R1 R2 sync", exp_ts, 4'h0, 8'h2A, 16'hBEEF);
  endtask

  task automatic t_events;
    for (int t = 1; t < 4; t++) begin
      frame(1, 0, 4'h0, 4'(t), 8'(t + 5), 16'(16'h0100 * t + 1), 2); idle(3);
      expect_rec("R2 event type", exp_ts, 4'(t), 8'(t + 5), 16'(16'h0100 * t + 1));
    end
  endtask

  task automatic t_general;
    for (int t = 8; t < 14; t++) begin
      frame(1, 0, 4'h0, 4'(t), 8'h01, 16'h0042, 2); idle(3);
      expect_none("R3 general type");
    end
  endtask

  task automatic t_reserved;
    for (int t = 4; t < 16; t++) begin
      if (t >= 8 && t <= 13) continue;
      frame(1, 0, 4'h0, 4'(t), 8'h01, 16'h0043, 2); idle(3);
      expect_none("R4 reserved type");
    end
  endtask

  task automatic t_tspec;
    frame(1, 0, 4'h1, 4'h1, 8'h09, 16'h1111, 0); idle(3);
    expect_rec("R5 tspec 1 enabled", exp_ts, 4'h1, 8'h09, 16'h1111);
    frame(1, 0, 4'h2, 4'h0, 8'h09, 16'h2222, 0); idle(3);
    expect_none("R5 tspec 2 masked");
    cfg_ts_mask = 16'h0001;
    frame(1, 0, 4'h1, 4'h0, 8'h09, 16'h3333, 0); idle(3);
    expect_none("R5 tspec 1 masked");
    cfg_ts_mask = 16'h0003;
  endtask

  task automatic t_ethertype;
    int hs;
    build(1, 0, 4'h0, 4'h0, 8'h05, 16'h0505, hs);
    frm[13] = 8'h00;
    send(hs + 36); idle(3);
    expect_none("R6 wrong ethertype low");
    build(1, 0, 4'h0, 4'h0, 8'h05, 16'h0506, hs);
    frm[12] = 8'h08;
    send(hs + 36); idle(3);
    expect_none("R6 wrong ethertype high");
  endtask

  task automatic t_offset;
    cfg_raw = 0; cfg_hdr_offset = 8'd42;
    frame(0, 42, 4'h0, 4'h3, 8'h77, 16'hA5A5, 3); idle(3);
    expect_rec("R7 offset 42", exp_ts, 4'h3, 8'h77, 16'hA5A5);
    cfg_hdr_offset = 8'd0;
    frame(0, 0, 4'h0, 4'h2, 8'h66, 16'h5A5A, 0); idle(3);
    expect_rec("R7 offset 0", exp_ts, 4'h2, 8'h66, 16'h5A5A);
    cfg_raw = 1;
  endtask

  task automatic t_short;
    int hs;
    build(1, 0, 4'h0, 4'h0, 8'h11, 16'h0C0C, hs);
    send(hs + 33); idle(3);
    expect_none("R8 header cut short");
    build(1, 0, 4'h0, 4'h1, 8'h12, 16'h0D0D, hs);
    send(hs + 34); idle(3);
    expect_rec("R8 exact header", exp_ts, 4'h1, 8'h12, 16'h0D0D);
  endtask

  task automatic t_backpressure;
    logic [47:0] t0, t1;
    frame(1, 0, 4'h0, 4'h0, 8'h21, 16'h0001, 0); t0 = exp_ts;
    frame(1, 0, 4'h0, 4'h1, 8'h22, 16'h0002, 0); t1 = exp_ts;
    idle(8);
    chk(rec_seq === 16'h0001, "R9 held while stalled", 64'(rec_seq), 1);
    expect_rec("R9 first out", t0, 4'h0, 8'h21, 16'h0001);
    expect_rec("R9 second out", t1, 4'h1, 8'h22, 16'h0002);
    expect_none("R9 drained");
  endtask

  task automatic t_overflow;
    for (int k = 0; k < 6; k++) begin
      frame(1, 0, 4'h0, 4'h0, 8'h30, 16'(16'h0050 + k), 0);
      ts_log[k] = exp_ts;
    end
    idle(3);
    chk(ovf_count === 16'd2, "R10 overflow count", 64'(ovf_count), 2);
    for (int k = 0; k < 4; k++)
      expect_rec("R10 kept record", ts_log[k], 4'h0, 8'h30, 16'(16'h0050 + k));
    expect_none("R10 dropped records absent");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1;
    idle(2);
    t_reset();
    t_sync();
    t_events();
    t_general();
    t_reserved();
    t_tspec();
    t_ethertype();
    t_offset();
    t_short();
    t_backpressure();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule